// File: doc/BRIEF.md
# Command Queue Starvation-Timeout Arbiter

This block is the command queue of a memory controller. It holds up to eight pending memory commands and each cycle offers one of them to the downstream scheduler. Requests enter through a valid/ready stream. Each request carries a transaction ID, a one-bit chip select and an opaque payload. An accepted request goes into the lowest-numbered free slot. The issue side is also a valid/ready stream, and a slot is released on the clock edge where its command is taken.

The normal choice is the entry that has waited longest, and an age order among the slots tracks this. Every entry also owns a countdown that starts when the entry is written. The countdown loads either a programmable default timeout or, when the request ID matches a configured quality-of-service ID, a separate QoS timeout. Once a countdown reaches zero, the entry is expired and outranks every entry that has not expired. This keeps any command from waiting without bound. The block also provides one queue-empty flag per chip select.

Input back-pressure: `in_ready` depends only on the stored occupancy and never on `out_ready`. Output back-pressure: while `out_ready` is low, `out_valid` stays high. The presented command changes only when some other entry becomes expired and takes priority.

Top module: `cmdq_starve_arb`

## Requirements
- R1: After reset the queue is empty: `in_ready`=1, `out_valid`=0, `chip_empty`=2'b11, QoS matching is off and the default timeout is all ones (0xFFF for the default 12-bit width).
- R2: `in_ready` is 1 exactly when fewer than DEPTH entries are held. A request is stored on an edge where `in_valid` and `in_ready` are both 1. While the queue is full, `in_valid` has no effect on the stored entries.
- R3: An entry accepted with timeout T shows `out_expired`-eligible state exactly T edges after its accept edge (T=0 means expired from the accept edge). It stays expired until it is issued.
- R4: Any expired entry wins over every non-expired entry. Among several expired entries, the one in the lowest slot index wins. An accepted request takes the lowest free slot index.
- R5: With no expired entry, the entry accepted earliest is presented, regardless of which slot it occupies.
- R6: `out_valid` is 1 whenever at least one entry is held. A command is issued and its slot freed on an edge with `out_valid` and `out_ready` both 1. `out_valid` never falls without an issue.
- R7: When `cfg_qos_en` is 1 and `in_id` equals `cfg_qos_id`, the entry loads `cfg_qos_tmo`. Otherwise it loads `cfg_tmo`, including when the ID matches but `cfg_qos_en` is 0.
- R8: `chip_empty[c]` is 1 exactly when no held entry has chip select c (bit 0 for chip 0, bit 1 for chip 1). It reflects the current entries with no added delay.
- R9: A `cfg_we` pulse loads all four configuration fields on that edge. The new values affect only requests accepted afterwards, and queued countdowns keep running.
- R10: `out_slot` gives the slot index and `out_expired` shows whether the presented entry won by expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load configuration fields |
| cfg_tmo | input | TMO_W | Default countdown value |
| cfg_qos_id | input | ID_W | ID that selects the QoS countdown |
| cfg_qos_tmo | input | TMO_W | QoS countdown value |
| cfg_qos_en | input | 1 | Enable QoS ID matching |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | A free slot exists |
| in_id | input | ID_W | Request transaction ID |
| in_chip | input | 1 | Request chip select |
| in_data | input | PLD_W | Request payload |
| out_valid | output | 1 | A command is presented |
| out_ready | input | 1 | Scheduler takes the presented command |
| out_id | output | ID_W | Presented ID |
| out_chip | output | 1 | Presented chip select |
| out_data | output | PLD_W | Presented payload |
| out_slot | output | IDX_W | Slot of the presented command |
| out_expired | output | 1 | Presented command won by expiry |
| chip_empty | output | 2 | Per-chip queue-empty flags |

## Verification
The bench uses the default parameters: eight slots and 12-bit IDs and timeouts. At these values the queue fills with eight pushes, so the full-queue case can be reached. A QoS timeout of three cycles produces expiry within a few cycles, while the default countdowns stay far from zero. The tests free a low slot and refill it, which separates oldest-first order from lowest-slot order. Two entries expire together, one of them in a lower but younger slot. A timeout of zero covers immediate expiry.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  // Chip-select encoding used by the per-chip empty flags.
  typedef enum logic {
    CS_LO = 1'b0,
    CS_HI = 1'b1
  } chip_sel_e;

  // Which rule chose the presented entry.
  typedef enum logic [1:0] {
    PICK_NONE   = 2'd0,
    PICK_AGED   = 2'd1,
    PICK_OLDEST = 2'd2
  } pick_src_e;
endpackage

// File: rtl/cmdq_slot.sv
module cmdq_slot #(
  parameter int ID_W  = 12,
  parameter int PLD_W = 16,
  parameter int TMO_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMO_W-1:0] load_tmo,
  input  logic [ID_W-1:0]  load_id,
  input  logic             load_chip,
  input  logic [PLD_W-1:0] load_data,
  input  logic             issue,
  output logic             vld,
  output logic             expired,
  output logic [ID_W-1:0]  id,
  output logic             chip,
  output logic [PLD_W-1:0] data
);
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      cnt  <= '0;
      id   <= '0;
      chip <= 1'b0;
      data <= '0;
    end else if (load) begin
      vld  <= 1'b1;
      cnt  <= load_tmo;
      id   <= load_id;
      chip <= load_chip;
      data <= load_data;
    end else if (issue) begin
      vld <= 1'b0;
    end else if (vld && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = vld && (cnt == '0);

  // R2: a slot is only written while free
  a_r2_load_free: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !vld);
  // R3: once expired, the entry stays expired until issued
  a_r3_hold_expired: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !issue && !load) |=> expired);
  // R6: an issued slot is empty on the next cycle
  a_r6_issue_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !load) |=> !vld);
endmodule

// File: rtl/cmdq_age.sv
module cmdq_age #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] vld,
  input  logic [DEPTH-1:0] alloc,
  output logic [DEPTH-1:0] oldest
);
  // older[i][j] = 1 means slot i was written before slot j
  logic [DEPTH-1:0] older [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) older[i] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        if (alloc[k]) begin
          older[k] <= '0;
          for (int j = 0; j < DEPTH; j++)
            if (j != k) older[j][k] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      oldest[i] = vld[i];
      for (int j = 0; j < DEPTH; j++)
        if ((j != i) && vld[j] && !older[i][j]) oldest[i] = 1'b0;
    end
  end

  // R5: exactly one oldest entry whenever any entry is held
  a_r5_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(oldest) && ((vld != '0) -> (oldest != '0)));
endmodule

// File: rtl/cmdq_pick.sv
module cmdq_pick
  import cmdq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] vld,
  input  logic [DEPTH-1:0] expired,
  input  logic [DEPTH-1:0] oldest,
  output logic [DEPTH-1:0] grant_oh,
  output logic [IDX_W-1:0] grant_idx,
  output pick_src_e        src
);
  logic [DEPTH-1:0] low_aged;

  // isolate the lowest set bit of the expired vector
  assign low_aged = expired & (~expired + 1'b1);

  always_comb begin
    if (expired != '0) begin
      grant_oh = low_aged;
      src      = PICK_AGED;
    end else if (vld != '0) begin
      grant_oh = oldest;
      src      = PICK_OLDEST;
    end else begin
      grant_oh = '0;
      src      = PICK_NONE;
    end
  end

  always_comb begin
    grant_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (grant_oh[i]) grant_idx = IDX_W'(i);
  end

  // R4: an expired entry is chosen whenever one exists
  a_r4_aged_first: assert property (@(posedge clk) disable iff (!rst_n)
    (expired != '0) |-> ((grant_oh & expired) != '0));
  // R4: no lower slot holds an expired entry than the one chosen
  a_r4_lowest_aged: assert property (@(posedge clk) disable iff (!rst_n)
    (expired != '0) |-> (((grant_oh - 1'b1) & expired) == '0));
  // R6: exactly one grant while anything is held
  a_r6_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (vld != '0) |-> ($countones(grant_oh) == 1));
endmodule

// File: rtl/cmdq_starve_arb.sv
module cmdq_starve_arb
  import cmdq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ID_W  = 12,
  parameter int TMO_W = 12,
  parameter int PLD_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [TMO_W-1:0] cfg_tmo,
  input  logic [ID_W-1:0]  cfg_qos_id,
  input  logic [TMO_W-1:0] cfg_qos_tmo,
  input  logic             cfg_qos_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ID_W-1:0]  in_id,
  input  logic             in_chip,
  input  logic [PLD_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ID_W-1:0]  out_id,
  output logic             out_chip,
  output logic [PLD_W-1:0] out_data,
  output logic [IDX_W-1:0] out_slot,
  output logic             out_expired,
  output logic [1:0]       chip_empty
);
  // configuration registers
  logic [TMO_W-1:0] dflt_tmo_q, qos_tmo_q;
  logic [ID_W-1:0]  qos_id_q;
  logic             qos_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dflt_tmo_q <= '1;
      qos_tmo_q  <= '0;
      qos_id_q   <= '0;
      qos_en_q   <= 1'b0;
    end else if (cfg_we) begin
      dflt_tmo_q <= cfg_tmo;
      qos_tmo_q  <= cfg_qos_tmo;
      qos_id_q   <= cfg_qos_id;
      qos_en_q   <= cfg_qos_en;
    end
  end

  logic [DEPTH-1:0] vld, expired, oldest, free, alloc, grant_oh, issue;
  logic [ID_W-1:0]  s_id   [DEPTH];
  logic             s_chip [DEPTH];
  logic [PLD_W-1:0] s_data [DEPTH];
  logic [IDX_W-1:0] grant_idx;
  pick_src_e        src;
  logic             accept, take;
  logic [TMO_W-1:0] load_tmo;

  assign free     = ~vld;
  assign in_ready = (free != '0);
  assign accept   = in_valid && in_ready;
  assign alloc    = accept ? (free & (~free + 1'b1)) : '0;
  assign load_tmo = (qos_en_q && (in_id == qos_id_q)) ? qos_tmo_q : dflt_tmo_q;

  assign out_valid = (vld != '0);
  assign take      = out_valid && out_ready;
  assign issue     = take ? grant_oh : '0;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    cmdq_slot #(.ID_W(ID_W), .PLD_W(PLD_W), .TMO_W(TMO_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (alloc[g]),
      .load_tmo  (load_tmo),
      .load_id   (in_id),
      .load_chip (in_chip),
      .load_data (in_data),
      .issue     (issue[g]),
      .vld       (vld[g]),
      .expired   (expired[g]),
      .id        (s_id[g]),
      .chip      (s_chip[g]),
      .data      (s_data[g])
    );
  end

  cmdq_age #(.DEPTH(DEPTH)) u_age (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld    (vld),
    .alloc  (alloc),
    .oldest (oldest)
  );

  cmdq_pick #(.DEPTH(DEPTH)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .vld       (vld),
    .expired   (expired),
    .oldest    (oldest),
    .grant_oh  (grant_oh),
    .grant_idx (grant_idx),
    .src       (src)
  );

  assign out_id      = s_id[grant_idx];
  assign out_chip    = s_chip[grant_idx];
  assign out_data    = s_data[grant_idx];
  assign out_slot    = grant_idx;
  assign out_expired = (src == PICK_AGED);

  always_comb begin
    chip_empty = 2'b11;
    for (int i = 0; i < DEPTH; i++)
      if (vld[i]) chip_empty[chip_sel_e'(s_chip[i])] = 1'b0;
  end

  // R6: a presented command is withdrawn only by issuing it
  a_r6_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  // R2: a full queue gains no entries
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> ($countones(vld) <= $countones($past(vld))));
  // R8: an empty queue reports both chips empty
  a_r8_all_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (chip_empty == 2'b11));
endmodule

// File: tb/cmdq_starve_arb_test.sv
module cmdq_starve_arb_test;
  localparam int DEPTH = 8;
  localparam int ID_W  = 12;
  localparam int TMO_W = 12;
  localparam int PLD_W = 16;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int ITEM_W = ID_W + 1 + PLD_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_qos_en = 1'b0;
  logic [TMO_W-1:0] cfg_tmo = '0, cfg_qos_tmo = '0;
  logic [ID_W-1:0] cfg_qos_id = '0;
  logic in_valid = 1'b0, in_chip = 1'b0, out_ready = 1'b0;
  logic [ID_W-1:0] in_id = '0;
  logic [PLD_W-1:0] in_data = '0;
  logic in_ready, out_valid, out_chip, out_expired;
  logic [ID_W-1:0] out_id;
  logic [PLD_W-1:0] out_data;
  logic [IDX_W-1:0] out_slot;
  logic [1:0] chip_empty;

  int checks = 0;
  int errors = 0;
  logic [ITEM_W-1:0] exp_q [$];

  always #4 clk = ~clk;

  cmdq_starve_arb #(.DEPTH(DEPTH), .ID_W(ID_W), .TMO_W(TMO_W), .PLD_W(PLD_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tmo(cfg_tmo),
    .cfg_qos_id(cfg_qos_id), .cfg_qos_tmo(cfg_qos_tmo), .cfg_qos_en(cfg_qos_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id), .in_chip(in_chip),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_id(out_id), .out_chip(out_chip), .out_data(out_data),
    .out_slot(out_slot), .out_expired(out_expired), .chip_empty(chip_empty)
  );

  function automatic logic [PLD_W-1:0] pld_of(input logic [ID_W-1:0] id);
    return PLD_W'(id) ^ 16'hA5C3;
  endfunction

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_item(input logic [ID_W-1:0] id, input logic chip);
    exp_q.push_back({id, chip, pld_of(id)});
  endtask

  task automatic push(input logic [ID_W-1:0] id, input logic chip);
    check(in_ready == 1'b1, "R2 ready before push", in_ready, 1);
    in_valid = 1'b1; in_id = id; in_chip = chip; in_data = pld_of(id);
    tick();
    in_valid = 1'b0;
  endtask

  task automatic set_cfg(input logic [TMO_W-1:0] t, input logic [ID_W-1:0] qid,
                         input logic [TMO_W-1:0] qt, input logic qen);
    cfg_we = 1'b1; cfg_tmo = t; cfg_qos_id = qid; cfg_qos_tmo = qt; cfg_qos_en = qen;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic drain();
    out_ready = 1'b1;
    for (int n = 0; n < 20 && out_valid; n++) tick();
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R6 drained", out_valid, 0);
    check(exp_q.size() == 0, "R6 scoreboard empty", exp_q.size(), 0);
  endtask

  // scoreboard monitor: compares each issued command with the expected order
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected issue", out_id, 0);
      end else begin
        logic [ITEM_W-1:0] e;
        e = exp_q.pop_front();
        check({out_id, out_chip, out_data} == e, "R4/R5 issue order",
              {out_id, out_chip, out_data}, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R6: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(chip_empty == 2'b11, "R1 chip_empty", chip_empty, 3);

    // R2, R8, R5: fill the queue, default timeout in force
    for (int i = 0; i < DEPTH; i++) begin
      push(ID_W'(12'h010 + i), ~i[0]);
      expect_item(ID_W'(12'h010 + i), ~i[0]);
      if (i == 0) check(chip_empty == 2'b01, "R8 only chip1 held", chip_empty, 1);
    end
    check(in_ready == 1'b0, "R2 full", in_ready, 0);
    check(chip_empty == 2'b00, "R8 both chips held", chip_empty, 0);
    in_valid = 1'b1; in_id = 12'h099; in_chip = 1'b0; in_data = pld_of(12'h099);
    repeat (2) tick();
    in_valid = 1'b0;
    check(out_id == 12'h010, "R2 full ignores input", out_id, 12'h010);
    repeat (20) tick();
    check(out_expired == 1'b0, "R1 default timeout large", out_expired, 0);
    drain();
    check(chip_empty == 2'b11, "R8 empty after drain", chip_empty, 3);
    check(in_ready == 1'b1, "R2 ready after drain", in_ready, 1);

    // R5: refilled low slot is younger than the higher slots
    push(12'h020, 1'b0); push(12'h021, 1'b0); push(12'h022, 1'b1);
    expect_item(12'h020, 1'b0); expect_item(12'h021, 1'b0);
    expect_item(12'h022, 1'b1); expect_item(12'h023, 1'b1);
    check(out_slot == 0, "R10 slot of oldest", out_slot, 0);
    out_ready = 1'b1; tick(); out_ready = 1'b0;
    push(12'h023, 1'b1);
    check(out_id == 12'h021, "R5 oldest not lowest slot", out_id, 12'h021);
    check(out_slot == 1, "R10 slot report", out_slot, 1);
    drain();

    // R3, R7, R4: QoS entry expires after 3 edges and jumps the queue
    set_cfg(12'h100, 12'h055, 12'd3, 1'b1);
    push(12'h031, 1'b0); push(12'h032, 1'b0); push(12'h055, 1'b1);
    check(out_id == 12'h031 && !out_expired, "R3 not yet expired", out_id, 12'h031);
    tick(); tick();
    check(out_expired == 1'b0, "R3 not early", out_expired, 0);
    tick();
    check(out_expired == 1'b1, "R3 expired on time", out_expired, 1);
    check(out_id == 12'h055, "R7 QoS timeout used", out_id, 12'h055);
    check(out_slot == 2, "R10 expired slot", out_slot, 2);
    repeat (5) tick();
    check(out_id == 12'h055 && out_expired, "R3 stays expired", out_id, 12'h055);
    expect_item(12'h055, 1'b1); expect_item(12'h031, 1'b0); expect_item(12'h032, 1'b0);
    drain();

    // R4: two expired entries, lower slot is the younger one
    push(12'h041, 1'b0); push(12'h055, 1'b1);
    expect_item(12'h041, 1'b0);
    out_ready = 1'b1; tick(); out_ready = 1'b0;
    in_data = 16'h0;
    push(12'h055, 1'b0);
    repeat (6) tick();
    check(out_slot == 0 && out_chip == 1'b0, "R4 lowest expired slot", out_slot, 0);
    expect_item(12'h055, 1'b0); expect_item(12'h055, 1'b1);
    drain();

    // R7 disabled match uses default, R9 later config leaves queued count alone
    set_cfg(12'd2, 12'h055, 12'h200, 1'b0);
    push(12'h055, 1'b1);
    check(out_expired == 1'b0, "R3 fresh entry", out_expired, 0);
    set_cfg(12'h300, 12'h055, 12'h200, 1'b0);
    tick();
    check(out_expired == 1'b1, "R7/R9 default kept for queued entry", out_expired, 1);
    expect_item(12'h055, 1'b1);
    drain();

    // R3 zero timeout: expired from the accept edge
    set_cfg(12'd0, 12'h055, 12'h200, 1'b0);
    push(12'h077, 1'b0);
    check(out_expired == 1'b1, "R3 zero timeout", out_expired, 1);
    expect_item(12'h077, 1'b0);
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule